// File: doc/BRIEF.md
# Clock Generator Configuration Slave (Two-Wire)

This block is a two-wire serial slave for the configuration side of a clock generator. It watches an open-drain SCL/SDA pair, which it samples through synchronizers in the system clock domain. It detects START and STOP and decodes a control byte. When that byte carries the fixed family code and the block's own three select bits, the block accepts a command byte and then the data bytes that the command calls for. Each accepted byte gets an ACK. A byte that is refused gets a NACK, and the rest of that transfer is ignored.

Commands come in three kinds. Some pick a two-byte register, some pick a one-byte register, and one is a standalone command with no data bytes that starts a nonvolatile save. The save is modelled only as a busy window of fixed length. While that window is open, every control byte gets a NACK. A read is a write of the command byte followed by a repeated START and a control byte with the read bit set. The register picked by the last command is then returned most significant byte first.

Top module: `clkcfg_twowire_slave`

## Requirements
- R1: After reset, SDA is released (`sda_oe_o` = 0), the divider and mux registers are 0x0000, the bus byte is 0x00 and the select bits equal the RST_SEL parameter (default 0).
- R2: A control byte is acknowledged only when bits [7:4] are 1011 and bits [3:1] equal the stored select bits. Bit 0 is the direction, 1 meaning read. Any other control byte is not acknowledged, and the transfer is then ignored.
- R3: A write of the divider (command 0xA1) or the mux (command 0xA2) takes the MSB first and then the LSB, and each data byte gets an ACK.
- R4: A two-byte write that stops after the MSB changes only the upper byte of the register.
- R5: A read returns the register picked by the last command byte, MSB first, for as long as the master acknowledges. Every byte past the register's width reads 0xFF.
- R6: Only the command codes 0xA1 to 0xA5 are acknowledged. A data byte past the width of the command (2 bytes for 0xA1/0xA2, 1 byte for 0xA3/0xA4, 0 bytes for 0xA5) gets a NACK and leaves the register unchanged.
- R7: Command 0xA5 is standalone and opens a busy window of BUSY_CYC system clocks. During that window every control byte gets a NACK and no register changes. After the window, transfers are acknowledged again.
- R8: Command 0xA3 writes the select bits from data bits [2:0] and reads back as {5'b0, select}. The new value governs the match from the next control byte on.
- R9: A repeated START at any point drops the byte in progress and returns the slave to control-byte reception.
- R10: The slave pulls SDA low only in ACK slots and read data bits, and it changes SDA only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND bus) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| cfg_div_o | output | 16 | Divider configuration register |
| cfg_mux_o | output | 16 | Mux configuration register |
| cfg_bus_o | output | 8 | Bus-side configuration byte |

## Verification
An ACK or a read data bit shows on SDA three system clocks after the SCL falling edge that ends the previous bit. That is two synchronizer flops plus the state register. The bench therefore holds each SCL quarter phase for five clocks and samples SDA in the middle of the SCL high time, well after the value has settled. Register outputs update three clocks after the eighth SCL rise of a data byte, and the bench reads them only after the STOP that follows. The busy window is checked twice: a control byte sent soon after the save command must get a NACK, and one sent after BUSY_CYC clocks have passed must get an ACK.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
    localparam logic [3:0] FAMILY   = 4'b1011;
    localparam logic [7:0] CMD_DIV  = 8'hA1;
    localparam logic [7:0] CMD_MUX  = 8'hA2;
    localparam logic [7:0] CMD_ADR  = 8'hA3;
    localparam logic [7:0] CMD_BUS  = 8'hA4;
    localparam logic [7:0] CMD_SAVE = 8'hA5;

    typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} link_state_e;
    typedef enum logic [1:0] {P_CTRL, P_CMD, P_DATA} phase_e;

    function automatic logic [1:0] cmd_width(input logic [7:0] c);
        case (c)
            CMD_DIV, CMD_MUX: return 2'd2;
            CMD_ADR, CMD_BUS: return 2'd1;
            default:          return 2'd0;
        endcase
    endfunction

    function automatic logic cmd_known(input logic [7:0] c);
        return c inside {CMD_DIV, CMD_MUX, CMD_ADR, CMD_BUS, CMD_SAVE};
    endfunction
endpackage

// File: rtl/clkcfg_line_sync.sv
module clkcfg_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    typedef struct packed {
        logic [2:0] scl;
        logic [2:0] sda;
    } pipe_t;

    pipe_t p_d, p_q;

    always_comb begin
        p_d.scl = {p_q.scl[1:0], scl_i};
        p_d.sda = {p_q.sda[1:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '1;
        else        p_q <= p_d;
    end

    assign scl_lvl   = p_q.scl[1];
    assign sda_lvl   = p_q.sda[1];
    assign scl_rise  = p_q.scl[1] & ~p_q.scl[2];
    assign scl_fall  = ~p_q.scl[1] & p_q.scl[2];
    assign bus_start = p_q.scl[1] & p_q.scl[2] & p_q.sda[2] & ~p_q.sda[1];
    assign bus_stop  = p_q.scl[1] & p_q.scl[2] & ~p_q.sda[2] & p_q.sda[1];

    // R9: a START and a STOP never show together
    a_r9_one_condition: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_start, bus_stop, scl_rise, scl_fall}) || !(bus_start && bus_stop));
endmodule

// File: rtl/clkcfg_regs.sv
module clkcfg_regs
    import clkcfg_pkg::*;
#(
    parameter int         BUSY_CYC = 200,
    parameter logic [2:0] RST_SEL  = 3'd0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  wr_cmd,
    input  logic [1:0]  wr_idx,
    input  logic [7:0]  wr_data,
    input  logic        save_go,
    input  logic [7:0]  rd_cmd,
    input  logic [1:0]  rd_idx,
    output logic [7:0]  rd_byte,
    output logic        busy,
    output logic [2:0]  sel,
    output logic [15:0] cfg_div,
    output logic [15:0] cfg_mux,
    output logic [7:0]  cfg_bus
);
    localparam int CW = $clog2(BUSY_CYC + 1);

    typedef struct packed {
        logic [15:0]   div;
        logic [15:0]   mux;
        logic [7:0]    bus;
        logic [2:0]    sel;
        logic [CW-1:0] left;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (wr_cmd)
                CMD_DIV: if (wr_idx == 2'd0) r_d.div[15:8] = wr_data; else r_d.div[7:0] = wr_data;
                CMD_MUX: if (wr_idx == 2'd0) r_d.mux[15:8] = wr_data; else r_d.mux[7:0] = wr_data;
                CMD_ADR: r_d.sel = wr_data[2:0];
                CMD_BUS: r_d.bus = wr_data;
                default: ;
            endcase
        end
        if (r_q.left != '0) r_d.left = r_q.left - 1'b1;
        if (save_go)        r_d.left = CW'(BUSY_CYC);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.sel  <= RST_SEL;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rd_byte = 8'hFF;
        if (rd_idx < cmd_width(rd_cmd)) begin
            case (rd_cmd)
                CMD_DIV: rd_byte = (rd_idx == 2'd0) ? r_q.div[15:8] : r_q.div[7:0];
                CMD_MUX: rd_byte = (rd_idx == 2'd0) ? r_q.mux[15:8] : r_q.mux[7:0];
                CMD_ADR: rd_byte = {5'b0, r_q.sel};
                CMD_BUS: rd_byte = r_q.bus;
                default: rd_byte = 8'hFF;
            endcase
        end
    end

    assign busy    = (r_q.left != '0);
    assign sel     = r_q.sel;
    assign cfg_div = r_q.div;
    assign cfg_mux = r_q.mux;
    assign cfg_bus = r_q.bus;

    // R7: the busy window opens only after a save request
    a_r7_busy_from_save: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(save_go));
    // R7: no register write is accepted during the busy window
    a_r7_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wr_en);
    // R7: the window counter never exceeds its length
    a_r7_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.left <= CW'(BUSY_CYC));
endmodule

// File: rtl/clkcfg_twowire_slave.sv
module clkcfg_twowire_slave
    import clkcfg_pkg::*;
#(
    parameter int         BUSY_CYC = 200,
    parameter logic [2:0] RST_SEL  = 3'd0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe_o,
    output logic [15:0] cfg_div_o,
    output logic [15:0] cfg_mux_o,
    output logic [7:0]  cfg_bus_o
);
    typedef struct packed {
        link_state_e st;
        phase_e      ph;
        logic [3:0]  cnt;
        logic [6:0]  sh;
        logic        ack;
        logic        rd;
        logic [1:0]  idx;
        logic [7:0]  cmd;
        logic        oe;
    } ctl_t;

    ctl_t c_d, c_q;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
    logic wr_en, save_go, busy;
    logic [7:0] rd_byte, byte_in;
    logic [2:0] sel;

    clkcfg_line_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop)
    );

    clkcfg_regs #(.BUSY_CYC(BUSY_CYC), .RST_SEL(RST_SEL)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(c_q.cmd), .wr_idx(c_q.idx),
        .wr_data(byte_in), .save_go(save_go), .rd_cmd(c_q.cmd), .rd_idx(c_q.idx),
        .rd_byte(rd_byte), .busy(busy), .sel(sel),
        .cfg_div(cfg_div_o), .cfg_mux(cfg_mux_o), .cfg_bus(cfg_bus_o)
    );

    function automatic logic [1:0] sat_inc(input logic [1:0] v);
        return (v == 2'd3) ? v : v + 2'd1;
    endfunction

    assign byte_in = {c_q.sh, sda_lvl};

    always_comb begin
        c_d     = c_q;
        wr_en   = 1'b0;
        save_go = 1'b0;
        if (bus_start) begin
            c_d.st  = S_RX;
            c_d.ph  = P_CTRL;
            c_d.cnt = '0;
            c_d.oe  = 1'b0;
        end else if (bus_stop) begin
            c_d.st = S_IDLE;
            c_d.oe = 1'b0;
        end else begin
            case (c_q.st)
                S_RX: begin
                    if (scl_rise) begin
                        c_d.sh  = byte_in[6:0];
                        c_d.cnt = c_q.cnt + 4'd1;
                        if (c_q.cnt == 4'd7) begin
                            case (c_q.ph)
                                P_CTRL: begin
                                    c_d.ack = (byte_in[7:4] == FAMILY) && (byte_in[3:1] == sel) && !busy;
                                    c_d.rd  = byte_in[0];
                                    c_d.idx = '0;
                                end
                                P_CMD: begin
                                    c_d.ack = cmd_known(byte_in);
                                    c_d.cmd = byte_in;
                                    c_d.idx = '0;
                                    save_go = (byte_in == CMD_SAVE);
                                end
                                default: begin
                                    c_d.ack = (c_q.idx < cmd_width(c_q.cmd));
                                    wr_en   = c_d.ack;
                                    c_d.idx = sat_inc(c_q.idx);
                                end
                            endcase
                        end
                    end else if (scl_fall && c_q.cnt == 4'd8) begin
                        c_d.st = S_ACK;
                        c_d.oe = c_q.ack;
                    end
                end
                S_ACK: begin
                    if (scl_fall) begin
                        c_d.oe  = 1'b0;
                        c_d.cnt = '0;
                        if (!c_q.ack) begin
                            c_d.st = S_IDLE;
                        end else if (c_q.ph == P_CTRL && c_q.rd) begin
                            c_d.st  = S_TX;
                            c_d.sh  = rd_byte[6:0];
                            c_d.oe  = ~rd_byte[7];
                            c_d.idx = sat_inc(c_q.idx);
                        end else begin
                            c_d.st = S_RX;
                            c_d.ph = (c_q.ph == P_CTRL) ? P_CMD : P_DATA;
                        end
                    end
                end
                S_TX: begin
                    if (scl_rise) begin
                        c_d.cnt = c_q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (c_q.cnt == 4'd8) begin
                            c_d.oe = 1'b0;
                            c_d.st = S_MACK;
                        end else begin
                            c_d.oe = ~c_q.sh[6];
                            c_d.sh = {c_q.sh[5:0], 1'b0};
                        end
                    end
                end
                S_MACK: begin
                    if (scl_rise) begin
                        c_d.ack = ~sda_lvl;
                    end else if (scl_fall) begin
                        if (!c_q.ack) begin
                            c_d.st = S_IDLE;
                        end else begin
                            c_d.st  = S_TX;
                            c_d.cnt = '0;
                            c_d.sh  = rd_byte[6:0];
                            c_d.oe  = ~rd_byte[7];
                            c_d.idx = sat_inc(c_q.idx);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= S_IDLE;
            c_q.ph <= P_CTRL;
        end else begin
            c_q <= c_d;
        end
    end

    assign sda_oe_o = c_q.oe;

    // R10: the SDA drive changes only while synchronized SCL is low
    a_r10_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) |-> !scl_lvl);
    // R10: SDA is pulled only in an ACK slot or a read data bit
    a_r10_drive_window: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe_o |-> (c_q.st == S_ACK || c_q.st == S_TX));
    // R9: a START always lands in control-byte reception with SDA released
    a_r9_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> (c_q.st == S_RX && c_q.ph == P_CTRL && c_q.cnt == 4'd0 && !sda_oe_o));
    // R7: a save request comes only from an accepted command byte phase
    a_r7_save_in_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        save_go |-> (c_q.ph == P_CMD && scl_rise));
endmodule

// File: tb/test_clkcfg_twowire_slave.sv
module test_clkcfg_twowire_slave;
    localparam int Q    = 5;
    localparam int BUSY = 2000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [15:0] div_o, mux_o;
    logic [7:0]  bus_o;
    wire sda_bus = sda_m & ~sda_oe;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    clkcfg_twowire_slave #(.BUSY_CYC(BUSY), .RST_SEL(3'd0)) i_clkcfg_twowire_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_oe_o(sda_oe), .cfg_div_o(div_o), .cfg_mux_o(mux_o), .cfg_bus_o(bus_o)
    );

    task automatic qwait(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qwait(Q);
        scl_m = 1'b1; qwait(Q);
        sda_m = 1'b0; qwait(Q);
        scl_m = 1'b0; qwait(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qwait(Q);
        scl_m = 1'b1; qwait(Q);
        sda_m = 1'b1; qwait(2 * Q);
    endtask

    task automatic clk_bit(output logic seen);
        qwait(Q);
        scl_m = 1'b1; qwait(Q);
        seen = sda_bus; qwait(Q);
        scl_m = 1'b0; qwait(Q);
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i];
            clk_bit(s);
        end
        sda_m = 1'b1;
        clk_bit(s);
        ack = ~s;
    endtask

    task automatic rbyte(input logic mack, output logic [7:0] b);
        logic s;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(s);
            b[i] = s;
        end
        sda_m = ~mack;
        clk_bit(s);
        sda_m = 1'b1;
    endtask

    // write ctrl, command and up to two data bytes; returns acks
    task automatic wr_cmd(input logic [7:0] ctl, input logic [7:0] cmd, input int n,
                          input logic [7:0] d0, input logic [7:0] d1, output logic [3:0] acks);
        logic a;
        acks = '0;
        bus_start();
        wbyte(ctl, a); acks[0] = a;
        if (a) begin
            wbyte(cmd, a); acks[1] = a;
            if (n > 0) begin wbyte(d0, a); acks[2] = a; end
            if (n > 1) begin wbyte(d1, a); acks[3] = a; end
        end
        bus_stop();
    endtask

    task automatic rd_reg(input logic [7:0] wctl, input logic [7:0] cmd, input int n,
                          output logic [23:0] data);
        logic a;
        logic [7:0] b;
        data = '0;
        bus_start();
        wbyte(wctl, a);
        wbyte(cmd, a);
        bus_start();
        wbyte(wctl | 8'h01, a);
        for (int i = 0; i < n; i++) begin
            rbyte(i != n - 1, b);
            data = {data[15:0], b};
        end
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic a;
        logic [3:0] acks;
        logic [7:0] b;
        logic [23:0] rdv;

        qwait(5);
        rst_n = 1'b1;
        qwait(5);
        // R1 reset state
        check("R1 sda_oe", {31'd0, sda_oe}, 32'd0);
        check("R1 div", {16'd0, div_o}, 32'd0);
        check("R1 mux", {16'd0, mux_o}, 32'd0);
        check("R1 bus", {24'd0, bus_o}, 32'd0);

        // R2 sweep every control byte
        for (int v = 0; v < 256; v++) begin
            bus_start();
            wbyte(v[7:0], a);
            check($sformatf("R2 ctrl %02h", v), {31'd0, a}, {31'd0, v[7:1] == 7'b1011_000});
            if (a && v[0]) rbyte(1'b0, b);
            bus_stop();
        end

        // R3 two-byte writes
        wr_cmd(8'hB0, 8'hA1, 2, 8'h12, 8'h34, acks);
        check("R3 div acks", {28'd0, acks}, 32'hF);
        check("R3 div", {16'd0, div_o}, 32'h1234);
        wr_cmd(8'hB0, 8'hA2, 2, 8'hBE, 8'hEF, acks);
        check("R3 mux", {16'd0, mux_o}, 32'hBEEF);

        // R4 MSB only
        wr_cmd(8'hB0, 8'hA1, 1, 8'h56, 8'h00, acks);
        check("R4 div msb only", {16'd0, div_o}, 32'h5634);

        // R5 reads
        rd_reg(8'hB0, 8'hA1, 3, rdv);
        check("R5 div read", {8'd0, rdv}, 32'h5634FF);
        rd_reg(8'hB0, 8'hA2, 2, rdv);
        check("R5 mux read", {8'd0, rdv}, 32'h00BEEF);
        wr_cmd(8'hB0, 8'hA4, 1, 8'h5A, 8'h00, acks);
        check("R5 bus write", {24'd0, bus_o}, 32'h5A);
        rd_reg(8'hB0, 8'hA4, 2, rdv);
        check("R5 bus read past width", {8'd0, rdv}, 32'h005AFF);

        // R6 command code sweep
        for (int v = 8'hA0; v <= 8'hAF; v++) begin
            if (v == 8'hA5) continue;
            bus_start();
            wbyte(8'hB0, a);
            wbyte(v[7:0], a);
            bus_stop();
            check($sformatf("R6 cmd %02h", v), {31'd0, a}, {31'd0, v >= 8'hA1 && v <= 8'hA4});
        end
        wr_cmd(8'hB0, 8'hA4, 2, 8'h11, 8'h22, acks);
        check("R6 extra byte nack", {28'd0, acks}, 32'h7);
        check("R6 extra byte ignored", {24'd0, bus_o}, 32'h11);
        wr_cmd(8'hB0, 8'hA1, 2, 8'h56, 8'h34, acks);

        // R8 select bits
        wr_cmd(8'hB0, 8'hA3, 1, 8'hFD, 8'h00, acks);
        check("R8 adr write ack", {28'd0, acks}, 32'h7);
        wr_cmd(8'hB0, 8'hA4, 1, 8'h99, 8'h00, acks);
        check("R8 old select nack", {28'd0, acks}, 32'h0);
        rd_reg(8'hBA, 8'hA3, 1, rdv);
        check("R8 adr readback", {8'd0, rdv}, 32'h05);
        wr_cmd(8'hBA, 8'hA3, 1, 8'h00, 8'h00, acks);
        check("R8 restore", {28'd0, acks}, 32'h7);
        check("R8 bus untouched", {24'd0, bus_o}, 32'h11);

        // R9 repeated start mid data byte
        bus_start();
        wbyte(8'hB0, a);
        wbyte(8'hA1, a);
        for (int i = 0; i < 4; i++) begin
            sda_m = 1'b0;
            clk_bit(a);
        end
        bus_start();
        wbyte(8'hB0, a);
        check("R9 ctrl after restart", {31'd0, a}, 32'd1);
        wbyte(8'hA2, a);
        wbyte(8'h77, a);
        bus_stop();
        check("R9 div kept", {16'd0, div_o}, 32'h5634);
        check("R9 restart then mux msb", {16'd0, mux_o}, 32'h77EF);

        // R7 standalone save and busy window
        wr_cmd(8'hB0, 8'hA5, 1, 8'h00, 8'h00, acks);
        check("R7 save acks, data nack", {28'd0, acks}, 32'h3);
        wr_cmd(8'hB0, 8'hA1, 2, 8'hAA, 8'hBB, acks);
        check("R7 busy nack", {28'd0, acks}, 32'h0);
        check("R7 busy no write", {16'd0, div_o}, 32'h5634);
        qwait(BUSY);
        wr_cmd(8'hB0, 8'hA1, 2, 8'hAA, 8'hBB, acks);
        check("R7 resumed", {28'd0, acks}, 32'hF);
        check("R7 write after busy", {16'd0, div_o}, 32'hAABB);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule